// File: doc/BRIEF.md
# Luhn Check Digit Unit

This block computes the Luhn modulo-10 checksum over a stream of decimal digits. Each digit arrives as a 4-bit BCD nibble with a valid strobe, least significant (rightmost) digit first, and a last flag marks the final digit of a number. The unit never stores the number. It keeps a running sum modulo 10 and a one-bit position phase, so a number may be as long as the sender likes.

A mode input chooses between two uses. In check mode the incoming number already ends in its check digit, and the unit reports whether the number is well formed. In generate mode the number has no check digit yet, and the unit returns the digit that would make it valid. A nibble above 9 poisons the number it belongs to and forces a failing result. One clock after the digit marked last is accepted, a single-cycle done pulse comes out together with the result. The unit then starts afresh for the next number.

Top module: `luhn_unit`

## Requirements
- R1: After reset, out_done, out_pass and out_digit are all 0.
- R2: With in_mode = 0 (check), the first digit accepted is not doubled and every second digit after it is doubled. out_pass is 1 exactly when the folded total is a multiple of 10 and no nibble was above 9. out_digit is 0 in this mode.
- R3: With in_mode = 1 (generate), the first digit accepted is doubled, then every second digit after it. out_digit equals (10 - total mod 10) mod 10 and always lies in 0..9. out_pass is 1 when no nibble was above 9.
- R4: A doubled digit whose product is 10 or more contributes the product minus 9, which is the sum of its two decimal digits.
- R5: The internal running sum always stays within 0..9.
- R6: Any nibble above 9 within a number makes that number's result out_pass = 0 and out_digit = 0, however many valid digits follow it.
- R7: out_done is high for exactly one cycle, in the cycle after the clock edge that accepts the digit with in_last = 1. out_pass and out_digit are valid in that cycle.
- R8: After a result, the next number starts with a zero sum, no error and the first-digit phase, whatever the previous number held.
- R9: The mode is taken from in_mode on the first digit of a number. Changes to in_mode on later digits of the same number have no effect.
- R10: Cycles with in_valid = 0 between digits change neither the sum nor the position phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A digit is presented this cycle |
| in_digit | input | 4 | BCD digit, rightmost digit of the number first |
| in_last | input | 1 | This digit is the final one of the number |
| in_mode | input | 1 | 0 = check a complete number, 1 = generate its check digit |
| out_done | output | 1 | One-cycle pulse: result is ready |
| out_pass | output | 1 | Check mode: number valid; generate mode: no bad nibble |
| out_digit | output | 4 | Generated check digit (generate mode), else 0 |

## Verification
On every cycle the assertions check that the folded contribution of a BCD digit and the running sum stay within 0..9, that a bad nibble stays latched until its number ends, that out_done only follows the acceptance of a last digit, that a result with a bad nibble never passes, and that out_digit is a decimal digit. Only the bench scenarios can show that the sum is right: which positions get doubled in each mode, the exact generated digit, that mode changes in mid-number and idle gaps are ignored, and that one number leaves nothing behind for the next.

// File: rtl/luhn_pkg.sv
package luhn_pkg;
  // Width of one BCD digit on the input stream.
  localparam int unsigned DIGIT_W = 4;
  // Mode encoding seen at in_mode.
  localparam logic MODE_CHECK = 1'b0;
  localparam logic MODE_GEN   = 1'b1;
endpackage

// File: rtl/luhn_fold.sv
// Doubles a digit when asked and folds a two-digit product back to one digit.
module luhn_fold #(
  parameter int unsigned DW = luhn_pkg::DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] digit,
  input  logic          dbl,
  output logic [DW-1:0] val,
  output logic          bad
);
  localparam logic [DW:0] NINE = (DW+1)'(9);

  logic [DW:0] wide;
  logic [DW:0] twice;

  always_comb begin
    wide  = {1'b0, digit};
    twice = {digit, 1'b0};
    bad   = (wide > NINE);
    if (bad) begin
      val = '0;
    end else if (dbl) begin
      if (twice > NINE) val = DW'(twice - NINE);
      else              val = DW'(twice);
    end else begin
      val = digit;
    end
  end

  // R4: a legal digit, doubled or not, contributes a single decimal digit
  assert_fold_range_R4: assert property (@(posedge clk) disable iff (rst)
    !bad |-> ({1'b0, val} <= NINE));
endmodule

// File: rtl/luhn_acc.sv
// Running modulo-10 sum, position phase, latched mode and sticky error.
module luhn_acc #(
  parameter int unsigned DW = luhn_pkg::DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_mode,
  input  logic [DW-1:0] fold_val,
  input  logic          fold_bad,
  output logic          dbl,
  output logic [DW-1:0] next_sum,
  output logic          run_err,
  output logic          eff_gen
);
  localparam logic [DW:0] TEN = (DW+1)'(10);

  logic [DW-1:0] acc;
  logic          phase;
  logic          gen_q;
  logic          busy;
  logic          err;
  logic [DW:0]   raw;

  always_comb begin
    eff_gen  = busy ? gen_q : in_mode;
    // check: first digit plain; generate: first digit doubled
    dbl      = phase ^ eff_gen;
    raw      = {1'b0, acc} + {1'b0, fold_val};
    next_sum = (raw >= TEN) ? DW'(raw - TEN) : DW'(raw);
    run_err  = err | fold_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      phase <= 1'b0;
      gen_q <= luhn_pkg::MODE_CHECK;
      busy  <= 1'b0;
      err   <= 1'b0;
    end else if (in_valid) begin
      if (in_last) begin
        acc   <= '0;
        phase <= 1'b0;
        gen_q <= luhn_pkg::MODE_CHECK;
        busy  <= 1'b0;
        err   <= 1'b0;
      end else begin
        acc   <= next_sum;
        phase <= ~phase;
        gen_q <= eff_gen;
        busy  <= 1'b1;
        err   <= run_err;
      end
    end
  end

  // R5: the running sum never leaves 0..9
  assert_acc_range_R5: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, acc} < TEN));
  // R6: a bad nibble stays remembered until the number ends
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (err && !(in_valid && in_last)) |=> err);
  // R10: an idle cycle leaves the phase where it was
  assert_idle_phase_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase));
endmodule

// File: rtl/luhn_result.sv
// Registers the result and the done pulse.
module luhn_result #(
  parameter int unsigned DW = luhn_pkg::DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [DW-1:0] next_sum,
  input  logic          run_err,
  input  logic          eff_gen,
  output logic          done,
  output logic          pass,
  output logic [DW-1:0] digit
);
  localparam logic [DW-1:0] TEN_D  = DW'(10);
  localparam logic [DW-1:0] NINE_D = DW'(9);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      pass  <= 1'b0;
      digit <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        pass  <= !run_err && (eff_gen || (next_sum == '0));
        digit <= (eff_gen && !run_err && (next_sum != '0)) ? (TEN_D - next_sum) : '0;
      end
    end
  end

  // R7: done only follows the acceptance of a last digit
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fire));
  // R6: a number with a bad nibble never passes
  assert_err_fails_R6: assert property (@(posedge clk) disable iff (rst)
    (done && $past(run_err)) |-> (!pass && (digit == '0)));
  // R3: the generated digit is decimal
  assert_digit_range_R3: assert property (@(posedge clk) disable iff (rst)
    digit <= NINE_D);
endmodule

// File: rtl/luhn_unit.sv
module luhn_unit #(
  parameter int unsigned DW = luhn_pkg::DIGIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_digit,
  input  logic          in_last,
  input  logic          in_mode,
  output logic          out_done,
  output logic          out_pass,
  output logic [DW-1:0] out_digit
);
  logic          dbl;
  logic [DW-1:0] fold_val;
  logic          fold_bad;
  logic [DW-1:0] next_sum;
  logic          run_err;
  logic          eff_gen;
  logic          fire;

  assign fire = in_valid & in_last;

  luhn_fold #(.DW(DW)) u_fold (
    .clk(clk), .rst(rst), .digit(in_digit), .dbl(dbl),
    .val(fold_val), .bad(fold_bad)
  );

  luhn_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_mode(in_mode), .fold_val(fold_val), .fold_bad(fold_bad),
    .dbl(dbl), .next_sum(next_sum), .run_err(run_err), .eff_gen(eff_gen)
  );

  luhn_result #(.DW(DW)) u_res (
    .clk(clk), .rst(rst), .fire(fire), .next_sum(next_sum),
    .run_err(run_err), .eff_gen(eff_gen),
    .done(out_done), .pass(out_pass), .digit(out_digit)
  );
endmodule

// File: tb/sim_luhn_unit.sv
`timescale 1ns/1ps
module sim_luhn_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_digit = 4'd0;
  logic       in_last = 1'b0;
  logic       in_mode = 1'b0;
  logic       out_done;
  logic       out_pass;
  logic [3:0] out_digit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  luhn_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_digit(in_digit),
    .in_last(in_last), .in_mode(in_mode),
    .out_done(out_done), .out_pass(out_pass), .out_digit(out_digit)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model: nibble 0 of d is the rightmost digit.
  task automatic model(input bit gen, input int n, input logic [63:0] d,
                       output int e_pass, output int e_dig);
    int  sum = 0;
    bit  err = 0;
    for (int i = 0; i < n; i++) begin
      int v = int'(d[4*i +: 4]);
      bit twice = gen ? (i % 2 == 0) : (i % 2 == 1);
      if (v > 9) err = 1;
      else begin
        if (twice) begin
          v = 2 * v;
          if (v > 9) v = v - 9;
        end
        sum += v;
      end
    end
    sum = sum % 10;
    e_pass = (!err && (gen || sum == 0)) ? 1 : 0;
    e_dig  = (gen && !err) ? (10 - sum) % 10 : 0;
  endtask

  // Stream one number, then check result and the end of the done pulse.
  task automatic send(input string req, input bit gen, input int n,
                      input logic [63:0] d, input bit gaps, input bit flip);
    int ep, ed;
    model(gen, n, d, ep, ed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_digit = d[4*i +: 4];
      in_last  = (i == n - 1);
      in_mode  = (flip && i > 0) ? ~gen : gen;
      if (gaps && i < n - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_digit = 4'd7;
        in_mode  = ~gen;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    chk({req, " R7 done"}, int'(out_done), 1);
    chk({req, " pass"}, int'(out_pass), ep);
    chk({req, " digit"}, int'(out_digit), ed);
    @(negedge clk);
    chk({req, " R7 done drops"}, int'(out_done), 0);
  endtask

  task automatic t_reset();
    chk("R1 done", int'(out_done), 0);
    chk("R1 pass", int'(out_pass), 0);
    chk("R1 digit", int'(out_digit), 0);
  endtask

  task automatic t_check_mode();
    send("R2 valid number", 1'b0, 11, 64'h79927398713, 0, 0);
    chk("R2 expect pass", int'(out_pass), 1);
    send("R2 corrupted number", 1'b0, 11, 64'h79927398710, 0, 0);
    chk("R2 expect fail", int'(out_pass), 0);
    send("R2 single zero", 1'b0, 1, 64'h0, 0, 0);
    send("R2 single five", 1'b0, 1, 64'h5, 0, 0);
  endtask

  task automatic t_generate();
    send("R3 generate", 1'b1, 10, 64'h7992739871, 0, 0);
    chk("R3 known digit", int'(out_digit), 3);
    send("R3 all zero", 1'b1, 4, 64'h0000, 0, 0);
    send("R3 single five", 1'b1, 1, 64'h5, 0, 0);
    chk("R3 five gives nine", int'(out_digit), 9);
  endtask

  task automatic t_fold();
    send("R4 nines check", 1'b0, 8, 64'h99999999, 0, 0);
    send("R4 mixed gen", 1'b1, 6, 64'h567895, 0, 0);
    send("R4 fold check", 1'b0, 2, 64'h59, 0, 0);
    chk("R4 5 doubled folds to 1, plus 9", int'(out_pass), 1);
  endtask

  task automatic t_bad_nibble();
    send("R6 check with A", 1'b0, 5, 64'h12A45, 0, 0);
    send("R6 gen with F first", 1'b1, 4, 64'h123F, 0, 0);
    send("R6 gen with C last", 1'b1, 3, 64'hC12, 0, 0);
  endtask

  task automatic t_recover();
    send("R8 poisoned", 1'b1, 3, 64'h9B9, 0, 0);
    send("R8 clean after error", 1'b0, 11, 64'h79927398713, 0, 0);
    send("R8 leftover sum", 1'b1, 2, 64'h77, 0, 0);
    send("R8 fresh start", 1'b0, 2, 64'h18, 0, 0);
    chk("R8 18 passes", int'(out_pass), 1);
  endtask

  task automatic t_mode_flip();
    send("R9 gen, mode toggled", 1'b1, 10, 64'h7992739871, 0, 1);
    chk("R9 still 3", int'(out_digit), 3);
    send("R9 check, mode toggled", 1'b0, 11, 64'h79927398713, 0, 1);
  endtask

  task automatic t_gaps();
    send("R10 check with gaps", 1'b0, 11, 64'h79927398713, 1, 0);
    send("R10 gen with gaps", 1'b1, 7, 64'h3141592, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_check_mode();
    t_generate();
    t_fold();
    t_bad_nibble();
    t_recover();
    t_mode_flip();
    t_gaps();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule